// File: doc/BRIEF.md
# Lockstep Warp Divergence Mask Controller

This block holds the set of live lanes for a single 32-lane warp whose lanes all run the same instruction in the same cycle. When a data-dependent branch arrives with a condition bit per lane, the controller narrows the live set to the lanes whose condition is true. It saves the mask from before the branch, together with the lanes that are still waiting, on a small stack. An else strobe then hands the waiting lanes the second path. A reconverge strobe pops the entry and brings back the mask that was live before the branch. Each branch therefore costs up to two serialized path slots, and a slot counter makes that cost visible.

Branches may nest up to the stack depth. A branch whose condition is the same for every live lane does not split the warp. Its else path has no lanes and is skipped. Misuse sets a sticky error flag and leaves the mask and stack untouched. Misuse here means branching into a full stack, or an else or reconverge strobe with nothing on the stack.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset, the active mask is all ones (32'hFFFF_FFFF), the nesting depth is 0, the error flag is 0 and the slot counter is 0.
- R2: For a branch on a non-full stack where the live lanes hold both condition values, the next mask is `active & cond`. The depth rises by 1 and the slot counter rises by 1.
- R3: For a branch where every live lane has the same condition value, the mask is unchanged. An entry is still pushed, so the depth rises by 1, and the slot counter rises by 1.
- R4: An else strobe on a divergent entry sets the mask to the lanes that were live at the branch and had a false condition. The slot counter rises by 1.
- R5: An else strobe on an entry from a uniform branch changes neither the mask nor the slot counter.
- R6: A reconverge strobe pops the top entry, restores the mask saved at its branch, and lowers the depth by 1.
- R7: Branches nest up to DEPTH (default 4) levels. Each reconverge restores the mask of its own level.
- R8: The following are faults: a branch while the depth equals DEPTH, or an else or reconverge strobe at depth 0. A fault sets the error flag and leaves the mask, the depth and the slot counter unchanged.
- R9: The error flag stays set until reset.
- R10: When strobes coincide, only one is acted on. Reconverge beats else, and else beats branch. The losing strobes have no effect.
- R11: A branch costs two slots when it diverges and one slot when it is uniform.
- R12: The active mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch strobe |
| br_cond | input | 32 | Per-lane branch condition, bit i for lane i |
| else_valid | input | 1 | Start-second-path strobe |
| reconv_valid | input | 1 | Reconvergence strobe |
| active_mask | output | 32 | Live lanes, bit i for lane i |
| nest_depth | output | 3 | Number of stacked branch entries |
| err_flag | output | 1 | Sticky misuse flag |
| slot_count | output | 16 | Number of path slots issued, wraps |

## Verification
The split is tried with four kinds of condition: a contiguous half, a nested quarter inside it, an alternating-bit pattern, and conditions that are all-true or all-false over the live lanes. The half and alternating patterns show that the mask tracks lane positions rather than a count. The uniform cases tell the no-split path apart from a real divergence, through both the mask and the slot counter. Directed runs fill the stack to its limit and overflow it, pop and else on an empty stack, and drive coincident strobes to separate the priority order from a merged action.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_BRANCH = 2'd1,
    OP_ELSE   = 2'd2,
    OP_RECONV = 2'd3
  } mask_op_e;

  // One action per cycle: reconverge, then else, then branch.
  function automatic mask_op_e pick_op(input logic br, input logic els, input logic rc);
    if (rc)       return OP_RECONV;
    else if (els) return OP_ELSE;
    else if (br)  return OP_BRANCH;
    else          return OP_NONE;
  endfunction
endpackage

// File: rtl/simt_split.sv
module simt_split #(
  parameter int unsigned LANES = 32
) (
  input  logic [LANES-1:0] live,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] first_mask,
  output logic [LANES-1:0] second_mask,
  output logic             uniform
);
  function automatic logic [LANES-1:0] taken_of(input logic [LANES-1:0] m, input logic [LANES-1:0] c);
    return m & c;
  endfunction

  function automatic logic [LANES-1:0] fallthru_of(input logic [LANES-1:0] m, input logic [LANES-1:0] c);
    return m & ~c;
  endfunction

  logic [LANES-1:0] taken, fallthru;

  always_comb begin
    taken       = taken_of(live, cond);
    fallthru    = fallthru_of(live, cond);
    uniform     = (taken == '0) || (fallthru == '0);
    // All-false keeps the whole live set on the single issued path.
    first_mask  = (taken != '0) ? taken : live;
    second_mask = uniform ? '0 : fallthru;
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] in_saved,
  input  logic [LANES-1:0] in_second,
  output logic [LANES-1:0] top_saved,
  output logic [LANES-1:0] top_second,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [LANES-1:0] saved_q  [DEPTH];
  logic [LANES-1:0] second_q [DEPTH];
  logic [LW-1:0]    level_q;

  assign level = level_q;
  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        saved_q[g]  <= '0;
        second_q[g] <= '0;
      end else if (push && (level_q == LW'(g))) begin
        saved_q[g]  <= in_saved;
        second_q[g] <= in_second;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              level_q <= '0;
    else if (push && !full)  level_q <= level_q + LW'(1);
    else if (pop && !empty)  level_q <= level_q - LW'(1);
  end

  always_comb begin
    top_saved  = '0;
    top_second = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == LW'(i + 1)) begin
        top_saved  = saved_q[i];
        top_second = second_q[i];
      end
    end
  end
endmodule

// File: rtl/simt_slot_counter.sv
module simt_slot_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_cond,
  input  logic             else_valid,
  input  logic             reconv_valid,
  output logic [LANES-1:0] active_mask,
  output logic [LW-1:0]    nest_depth,
  output logic             err_flag,
  output logic [CNT_W-1:0] slot_count
);
  import simt_pkg::*;

  mask_op_e         op;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] first_mask, second_mask, top_saved, top_second;
  logic             uniform, full, empty;
  logic             do_push, do_pop, do_else, else_fires, fault, slot_issue;
  logic             err_q;

  assign op = pick_op(br_valid, else_valid, reconv_valid);

  simt_split #(.LANES(LANES)) u_split (
    .live        (mask_q),
    .cond        (br_cond),
    .first_mask  (first_mask),
    .second_mask (second_mask),
    .uniform     (uniform)
  );

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (do_push),
    .pop        (do_pop),
    .in_saved   (mask_q),
    .in_second  (second_mask),
    .top_saved  (top_saved),
    .top_second (top_second),
    .level      (nest_depth),
    .full       (full),
    .empty      (empty)
  );

  // Named events, also observed by the checker.
  assign do_push    = (op == OP_BRANCH) && !full;
  assign do_pop     = (op == OP_RECONV) && !empty;
  assign do_else    = (op == OP_ELSE)   && !empty;
  assign else_fires = do_else && (top_second != '0);
  assign fault      = ((op == OP_BRANCH) && full) ||
                      (((op == OP_ELSE) || (op == OP_RECONV)) && empty);
  assign slot_issue = do_push || else_fires;

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= '1;
    else if (do_push)    mask_q <= first_mask;
    else if (else_fires) mask_q <= top_second;
    else if (do_pop)     mask_q <= top_saved;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (fault) err_q <= 1'b1;
  end

  simt_slot_counter #(.CNT_W(CNT_W)) u_slots (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (slot_issue),
    .count (slot_count)
  );

  assign active_mask = mask_q;
  assign err_flag    = err_q;
endmodule

// File: rtl/simt_mask_ctrl_chk.sv
module simt_mask_ctrl_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] active_mask,
  input logic [LW-1:0]    nest_depth,
  input logic             err_flag,
  input logic [CNT_W-1:0] slot_count,
  input logic             do_push,
  input logic             do_pop,
  input logic             else_fires,
  input logic             fault,
  input logic [LANES-1:0] top_saved
);
  // R2: a branch never adds lanes
  a_r2_branch_subset: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> ((active_mask & ~$past(active_mask)) == '0));

  // R4: the second path shares no lane with the first
  a_r4_else_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    else_fires |=> ((active_mask & $past(active_mask)) == '0));

  // R6: a pop brings back the saved mask
  a_r6_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (active_mask == $past(top_saved)));

  // R7: depth within the stack size
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= LW'(DEPTH));

  // R8: a fault leaves the depth untouched and raises the flag
  a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (err_flag && $stable(nest_depth) && $stable(active_mask)));

  // R9: the flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R11: at most one slot per cycle
  a_r11_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_count == $past(slot_count)) ||
             (slot_count == $past(slot_count) + CNT_W'(1)));

  // R12: the mask is never empty
  a_r12_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);
endmodule

bind simt_mask_ctrl simt_mask_ctrl_chk #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active_mask (active_mask),
  .nest_depth  (nest_depth),
  .err_flag    (err_flag),
  .slot_count  (slot_count),
  .do_push     (do_push),
  .do_pop      (do_pop),
  .else_fires  (else_fires),
  .fault       (fault),
  .top_saved   (top_saved)
);

// File: tb/simt_mask_ctrl_tb.sv
module simt_mask_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int DEPTH = 4;
  localparam int CNT_W = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 15;

  // op: 1 branch, 2 else, 3 reconverge
  localparam logic [1:0]  V_OP   [NVEC] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd2, 2'd1, 2'd2, 2'd3,
                                            2'd3, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2, 2'd3};
  localparam logic [31:0] V_COND [NVEC] = '{32'h0000FFFF, 32'h000000FF, 32'h0, 32'h0, 32'h0,
                                            32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h00000000,
                                            32'h0, 32'h0, 32'hAAAAAAAA, 32'h0, 32'h0};
  localparam logic [31:0] V_MASK [NVEC] = '{32'h0000FFFF, 32'h000000FF, 32'h0000FF00, 32'h0000FFFF,
                                            32'hFFFF0000, 32'hFFFF0000, 32'hFFFF0000, 32'hFFFF0000,
                                            32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                            32'hAAAAAAAA, 32'h55555555, 32'hFFFFFFFF};
  localparam int          V_DEP  [NVEC] = '{1, 2, 2, 1, 1, 2, 2, 1, 0, 1, 1, 0, 1, 1, 0};
  localparam int          V_CNT  [NVEC] = '{1, 2, 3, 3, 4, 5, 5, 5, 5, 6, 6, 6, 7, 8, 8};
  localparam string       V_TAG  [NVEC] = '{"R2", "R7", "R4", "R6", "R4", "R3", "R5", "R6",
                                            "R7", "R3", "R5", "R11", "R2", "R4", "R6"};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_cond = '0;
  logic             else_valid = 1'b0;
  logic             reconv_valid = 1'b0;
  logic [LANES-1:0] active_mask;
  logic [LW-1:0]    nest_depth;
  logic             err_flag;
  logic [CNT_W-1:0] slot_count;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .br_cond      (br_cond),
    .else_valid   (else_valid),
    .reconv_valid (reconv_valid),
    .active_mask  (active_mask),
    .nest_depth   (nest_depth),
    .err_flag     (err_flag),
    .slot_count   (slot_count)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_all(input string tag, input logic [31:0] m, input int d, input logic e, input int c);
    chk(tag, "mask",  64'(active_mask), 64'(m));
    chk(tag, "depth", 64'(nest_depth),  64'(d));
    chk(tag, "err",   64'(err_flag),    64'(e));
    chk(tag, "slots", 64'(slot_count),  64'(c));
  endtask

  // Drive at a falling edge, hold over one rising edge, sample at the next falling edge.
  task automatic step(input logic b, input logic e, input logic r, input logic [31:0] c);
    @(negedge clk);
    br_valid = b; else_valid = e; reconv_valid = r; br_cond = c;
    @(negedge clk);
    br_valid = 1'b0; else_valid = 1'b0; reconv_valid = 1'b0; br_cond = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    expect_all("R1", 32'hFFFFFFFF, 0, 1'b0, 0);

    // Table walk: nested split, else, uniform true/false, alternating lanes.
    for (int i = 0; i < NVEC; i++) begin
      step(V_OP[i] == 2'd1, V_OP[i] == 2'd2, V_OP[i] == 2'd3, V_COND[i]);
      expect_all(V_TAG[i], V_MASK[i], V_DEP[i], 1'b0, V_CNT[i]);
    end

    // R7 / R8 / R9: fill the stack, overflow it, unwind.
    do_reset();
    step(1'b1, 1'b0, 1'b0, 32'h1);
    for (int k = 1; k < DEPTH; k++) step(1'b1, 1'b0, 1'b0, 32'h1);
    expect_all("R7", 32'h1, DEPTH, 1'b0, DEPTH);
    step(1'b1, 1'b0, 1'b0, 32'h0);
    expect_all("R8", 32'h1, DEPTH, 1'b1, DEPTH);
    for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b0, 1'b1, 32'h0);
    expect_all("R9", 32'hFFFFFFFF, 0, 1'b1, DEPTH);
    do_reset();
    expect_all("R1", 32'hFFFFFFFF, 0, 1'b0, 0);

    // R8: pop on empty stack.
    step(1'b0, 1'b0, 1'b1, 32'h0);
    expect_all("R8", 32'hFFFFFFFF, 0, 1'b1, 0);
    do_reset();
    // R8: else on empty stack.
    step(1'b0, 1'b1, 1'b0, 32'h0);
    expect_all("R8", 32'hFFFFFFFF, 0, 1'b1, 0);
    do_reset();

    // R10: reconverge beats else and branch.
    step(1'b1, 1'b0, 1'b0, 32'h0000000F);
    expect_all("R2", 32'h0000000F, 1, 1'b0, 1);
    step(1'b1, 1'b1, 1'b1, 32'h00000003);
    expect_all("R10", 32'hFFFFFFFF, 0, 1'b0, 1);
    // R10: else beats branch; else on empty faults, branch ignored.
    step(1'b1, 1'b1, 1'b0, 32'h00000003);
    expect_all("R10", 32'hFFFFFFFF, 0, 1'b1, 1);
    do_reset();
    // R10: else beats branch on a live entry.
    step(1'b1, 1'b0, 1'b0, 32'h00FF00FF);
    step(1'b1, 1'b1, 1'b0, 32'h0000000F);
    expect_all("R10", 32'hFF00FF00, 1, 1'b0, 2);
    step(1'b0, 1'b0, 1'b1, 32'h0);
    expect_all("R11", 32'hFFFFFFFF, 0, 1'b0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule